// File: doc/BRIEF.md
# Temperature Limit Alert Controller

This block watches a stream of signed 12-bit temperature samples, one per cycle in which the sample-valid strobe is high, and compares each one against a programmable upper limit and a programmable lower limit. A fault queue filters the result. The alert changes state only after a programmed run of consecutive qualifying samples. The queue length is 1, 2, 4 or 6 samples, chosen by a 2-bit code.

There are two alert modes. In comparator mode, the alert follows a hysteresis band. It becomes active at or above the upper limit and inactive below the lower limit. In interrupt mode, the alert latches when it fires. A register-read event, an alert-response acknowledge or shutdown entry releases it. Each clear re-arms the alert on the opposite threshold. A readable status bit always shows the comparator hysteresis state, whatever the mode. A polarity setting inverts both the alert pin and the status bit. A general reset restores every setting and all state to its power-up value.

The limit registers and the settings register live inside the block. Each has a write strobe. The A/D converter and the serial bus sit outside the block and drive these inputs.

Top module: `tempAlertCtrl`

## Requirements
- R1: After reset, the upper limit is 1280 (80 °C at 1/16 °C per LSB), the lower limit is 1200 (75 °C), the mode is comparator, the polarity is 0 and the fault code is 00. With these settings, alertPin and statusBit both read 1.
- R2: The fault code cfgFaultSel selects the run of consecutive qualifying samples needed for the alert to change state: 2'b00 needs 1, 2'b01 needs 2, 2'b10 needs 4 and 2'b11 needs 6. The output changes in the cycle after the clock edge that accepts the last sample of the run.
- R3: In comparator mode, with the alert inactive, the required run of samples at or above the upper limit makes the alert active.
- R4: In comparator mode, with the alert active, the required run of samples strictly below the lower limit makes the alert inactive. A sample equal to the lower limit does not count.
- R5: A valid sample that fails the condition being watched restarts the run from zero. Cycles with sampleValid low leave the run unchanged.
- R6: In interrupt mode (cfgIntMode=1), the alert fires after the required run at or above the upper limit. It stays active whatever the later samples are, until a clear event arrives.
- R7: In interrupt mode, a pulse on any of regReadClr, alertAckClr or shutdownClr releases an active alert.
- R8: In interrupt mode, each alert flips the armed threshold. After a high alert is cleared, only the required run strictly below the lower limit can fire the next alert. After that alert is cleared, the upper limit is armed again.
- R9: alertPin equals NOT(alert XOR cfgPolarity), so it is active low with polarity 0. statusBit equals NOT(hysteresis state XOR cfgPolarity), so it reads 1 while the upper condition has not been reached.
- R10: statusBit tracks the comparator hysteresis state in both modes. It changes only in the cycle after a valid sample, a settings write or a general reset.
- R11: Comparisons are signed two's-complement and use all 12 bits. Negative limits work, and the low bits of a limit decide the outcome.
- R12: A settings write that changes the mode restarts both runs. A sample presented in that same cycle is dropped. Entering interrupt mode starts with the alert inactive and the upper limit armed.
- R13: A genReset pulse has priority over everything else in its cycle. In the next cycle, all settings and state are back at the R1 values, and a sample presented with the pulse is dropped.
- R14: In interrupt mode, if a sample completes a run in the same cycle as a clear event, the alert fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A new temperature sample is present |
| sampleTemp | input | 12 | Signed temperature sample, 1/16 °C per LSB |
| highWrEn | input | 1 | Write strobe for the upper limit |
| highWrData | input | 12 | New upper limit |
| lowWrEn | input | 1 | Write strobe for the lower limit |
| lowWrData | input | 12 | New lower limit |
| cfgWrEn | input | 1 | Write strobe for the settings |
| cfgFaultSel | input | 2 | Fault queue code |
| cfgIntMode | input | 1 | 0 = comparator, 1 = interrupt |
| cfgPolarity | input | 1 | Output polarity |
| regReadClr | input | 1 | A register was read (clear event) |
| alertAckClr | input | 1 | Alert-response acknowledge (clear event) |
| shutdownClr | input | 1 | Shutdown entered (clear event) |
| genReset | input | 1 | Synchronous general reset |
| alertPin | output | 1 | Alert output |
| statusBit | output | 1 | Hysteresis status bit |

## Verification
The bench builds the block with its default parameters: 12-bit samples and power-up limits of 1280 and 1200. At this width, samples one LSB either side of every limit, including negative limits, are easy to reach. The longest fault queue, six samples, is reached in a handful of cycles. Directed walks through all four fault codes and through both interrupt arming states are followed by a randomized stretch. That stretch mixes settings writes, clears and general resets around the limits, so mode changes mid-run and clear-versus-fire collisions occur many times.

// File: rtl/tempAlertPkg.sv
package tempAlertPkg;

  localparam int FAULT_MAX = 6;
  localparam int CNT_W     = $clog2(FAULT_MAX + 1);

  // Strobes from control to datapath (run counters)
  typedef struct packed {
    logic cmpInc;
    logic cmpClr;
    logic intInc;
    logic intClr;
  } ctlStrobe_t;

  // Flags from datapath to control
  typedef struct packed {
    logic geHigh;
    logic ltLow;
    logic cmpLast;
    logic intLast;
    logic intMode;
    logic modeChange;
  } dpFlag_t;

  function automatic logic [CNT_W-1:0] faultNeed(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      2'b00:   n = CNT_W'(1);
      2'b01:   n = CNT_W'(2);
      2'b10:   n = CNT_W'(4);
      default: n = CNT_W'(6);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tempAlertDatapath.sv
module tempAlertDatapath
  import tempAlertPkg::*;
#(
  parameter int TEMP_W   = 12,
  parameter int HIGH_RST = 1280,
  parameter int LOW_RST  = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              genReset,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic              highWrEn,
  input  logic [TEMP_W-1:0] highWrData,
  input  logic              lowWrEn,
  input  logic [TEMP_W-1:0] lowWrData,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgFaultSel,
  input  logic              cfgIntMode,
  input  logic              cfgPolarity,
  input  ctlStrobe_t        strobe,
  output dpFlag_t           flags,
  output logic              polarity
);

  localparam logic [TEMP_W-1:0] HIGH_INIT = TEMP_W'(HIGH_RST);
  localparam logic [TEMP_W-1:0] LOW_INIT  = TEMP_W'(LOW_RST);
  localparam int NQ = 2;   // queue 0: comparator run, queue 1: interrupt run

  logic [TEMP_W-1:0] highReg, lowReg;
  logic [1:0]        faultReg;
  logic              modeReg, polReg;
  logic [CNT_W-1:0]  need;
  logic              modeChange;
  logic [NQ-1:0]     incVec, clrVec, lastVec;

  // Settings and limit registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      highReg  <= HIGH_INIT;
      lowReg   <= LOW_INIT;
      faultReg <= 2'b00;
      modeReg  <= 1'b0;
      polReg   <= 1'b0;
    end else if (genReset) begin
      highReg  <= HIGH_INIT;
      lowReg   <= LOW_INIT;
      faultReg <= 2'b00;
      modeReg  <= 1'b0;
      polReg   <= 1'b0;
    end else begin
      if (highWrEn) highReg <= highWrData;
      if (lowWrEn)  lowReg  <= lowWrData;
      if (cfgWrEn) begin
        faultReg <= cfgFaultSel;
        modeReg  <= cfgIntMode;
        polReg   <= cfgPolarity;
      end
    end
  end

  assign need       = faultNeed(faultReg);
  assign modeChange = cfgWrEn && (cfgIntMode != modeReg);

  assign incVec = {strobe.intInc, strobe.cmpInc};
  assign clrVec = {strobe.intClr, strobe.cmpClr};

  // Two identical consecutive-fault run counters
  for (genvar q = 0; q < NQ; q++) begin : gQueue
    logic [CNT_W-1:0] runCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        runCnt <= '0;
      else if (genReset || modeChange || clrVec[q])
        runCnt <= '0;
      else if (incVec[q])
        runCnt <= runCnt + 1'b1;
    end
    assign lastVec[q] = ({1'b0, runCnt} + 1'b1) >= {1'b0, need};
  end

  assign flags.geHigh     = $signed(sampleTemp) >= $signed(highReg);
  assign flags.ltLow      = $signed(sampleTemp) <  $signed(lowReg);
  assign flags.cmpLast    = lastVec[0];
  assign flags.intLast    = lastVec[1];
  assign flags.intMode    = modeReg;
  assign flags.modeChange = modeChange;
  assign polarity         = polReg;

endmodule

// File: rtl/tempAlertControl.sv
module tempAlertControl
  import tempAlertPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       genReset,
  input  logic       sampleValid,
  input  logic       regReadClr,
  input  logic       alertAckClr,
  input  logic       shutdownClr,
  input  dpFlag_t    flags,
  output ctlStrobe_t strobe,
  output logic       cmpState,
  output logic       intAlert
);

  logic armHigh;
  logic sampleEff, anyClr;
  logic cmpWatch, cmpHit, cmpFire;
  logic intWatch, intActive, intHit, intFire;

  assign sampleEff = sampleValid && !genReset && !flags.modeChange;
  assign anyClr    = regReadClr || alertAckClr || shutdownClr;

  // Comparator hysteresis run
  assign cmpWatch = cmpState ? flags.ltLow : flags.geHigh;
  assign cmpHit   = sampleEff && cmpWatch;
  assign cmpFire  = cmpHit && flags.cmpLast;

  // Interrupt run, armed on one threshold at a time
  assign intWatch  = armHigh ? flags.geHigh : flags.ltLow;
  assign intActive = flags.intMode && sampleEff && !intAlert;
  assign intHit    = intActive && intWatch;
  assign intFire   = intHit && flags.intLast;

  always_comb begin
    strobe.cmpInc = cmpHit && !cmpFire;
    strobe.cmpClr = sampleEff && (!cmpWatch || cmpFire);
    strobe.intInc = intHit && !intFire;
    strobe.intClr = !flags.intMode || (intActive && (!intWatch || intFire));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpState <= 1'b0;
      intAlert <= 1'b0;
      armHigh  <= 1'b1;
    end else if (genReset) begin
      cmpState <= 1'b0;
      intAlert <= 1'b0;
      armHigh  <= 1'b1;
    end else begin
      if (cmpFire) cmpState <= !cmpState;
      if (!flags.intMode) begin
        intAlert <= 1'b0;
        armHigh  <= 1'b1;
      end else if (intFire) begin
        intAlert <= 1'b1;
        armHigh  <= !armHigh;
      end else if (anyClr) begin
        intAlert <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tempAlertCtrl.sv
module tempAlertCtrl
  import tempAlertPkg::*;
#(
  parameter int TEMP_W   = 12,
  parameter int HIGH_RST = 1280,
  parameter int LOW_RST  = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic              highWrEn,
  input  logic [TEMP_W-1:0] highWrData,
  input  logic              lowWrEn,
  input  logic [TEMP_W-1:0] lowWrData,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgFaultSel,
  input  logic              cfgIntMode,
  input  logic              cfgPolarity,
  input  logic              regReadClr,
  input  logic              alertAckClr,
  input  logic              shutdownClr,
  input  logic              genReset,
  output logic              alertPin,
  output logic              statusBit
);

  ctlStrobe_t strobe;
  dpFlag_t    flags;
  logic       polarity;
  logic       cmpState, intAlert, alertLvl;

  tempAlertDatapath #(
    .TEMP_W  (TEMP_W),
    .HIGH_RST(HIGH_RST),
    .LOW_RST (LOW_RST)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .genReset   (genReset),
    .sampleTemp (sampleTemp),
    .highWrEn   (highWrEn),
    .highWrData (highWrData),
    .lowWrEn    (lowWrEn),
    .lowWrData  (lowWrData),
    .cfgWrEn    (cfgWrEn),
    .cfgFaultSel(cfgFaultSel),
    .cfgIntMode (cfgIntMode),
    .cfgPolarity(cfgPolarity),
    .strobe     (strobe),
    .flags      (flags),
    .polarity   (polarity)
  );

  tempAlertControl ctl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .genReset   (genReset),
    .sampleValid(sampleValid),
    .regReadClr (regReadClr),
    .alertAckClr(alertAckClr),
    .shutdownClr(shutdownClr),
    .flags      (flags),
    .strobe     (strobe),
    .cmpState   (cmpState),
    .intAlert   (intAlert)
  );

  assign alertLvl  = flags.intMode ? intAlert : cmpState;
  assign alertPin  = !(alertLvl ^ polarity);
  assign statusBit = !(cmpState ^ polarity);

endmodule

// File: rtl/tempAlertChecker.sv
module tempAlertChecker (
  input logic clk,
  input logic rst_n,
  input logic sampleValid,
  input logic cfgWrEn,
  input logic genReset,
  input logic regReadClr,
  input logic alertAckClr,
  input logic shutdownClr,
  input logic alertPin,
  input logic statusBit
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (alertPin && statusBit));  // R1

  AST_GENRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(genReset) |-> (alertPin && statusBit));  // R13

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sampleValid) && !$past(cfgWrEn) && !$past(genReset)) |-> $stable(statusBit));  // R10

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sampleValid) && !$past(cfgWrEn) && !$past(genReset) &&
     !$past(regReadClr) && !$past(alertAckClr) && !$past(shutdownClr)) |-> $stable(alertPin));  // R6

endmodule

bind tempAlertCtrl tempAlertChecker chk_i (.*);

// File: tb/tempAlertCtrl_tb_top.sv
`timescale 1ns/1ps
module tempAlertCtrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleTemp = '0;
  logic        highWrEn = 1'b0;
  logic [11:0] highWrData = '0;
  logic        lowWrEn = 1'b0;
  logic [11:0] lowWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgFaultSel = '0;
  logic        cfgIntMode = 1'b0;
  logic        cfgPolarity = 1'b0;
  logic        regReadClr = 1'b0;
  logic        alertAckClr = 1'b0;
  logic        shutdownClr = 1'b0;
  logic        genReset = 1'b0;
  logic        alertPin, statusBit;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  tempAlertCtrl dut_i (.*);

  // Behavioural reference model
  int mHigh, mLow, mFault, mInt, mPol, mCmp, mCmpCnt, mIntAlert, mArm, mIntCnt;

  function automatic int needOf(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int sx(logic [11:0] v);
    return int'($signed(v));
  endfunction

  task automatic modelReset();
    mHigh = 1280; mLow = 1200; mFault = 0; mInt = 0; mPol = 0;
    mCmp = 0; mCmpCnt = 0; mIntAlert = 0; mArm = 1; mIntCnt = 0;
  endtask

  task automatic modelStep();
    int t, watch, fire;
    bit chg, sv, ge, lt;
    if (!rst_n || genReset) begin
      modelReset();
      return;
    end
    chg = cfgWrEn && (int'(cfgIntMode) != mInt);
    sv  = sampleValid && !chg;
    t   = sx(sampleTemp);
    ge  = t >= mHigh;
    lt  = t < mLow;
    if (sv) begin
      watch = mCmp ? lt : ge;
      if (watch) begin
        mCmpCnt++;
        if (mCmpCnt >= needOf(mFault)) begin mCmp = !mCmp; mCmpCnt = 0; end
      end else mCmpCnt = 0;
    end
    if (mInt != 0) begin
      fire = 0;
      if (sv && !mIntAlert) begin
        watch = mArm ? ge : lt;
        if (watch) begin
          mIntCnt++;
          if (mIntCnt >= needOf(mFault)) begin fire = 1; mIntCnt = 0; end
        end else mIntCnt = 0;
      end
      if (fire) begin mIntAlert = 1; mArm = !mArm; end
      else if (regReadClr || alertAckClr || shutdownClr) mIntAlert = 0;
    end else begin
      mIntAlert = 0; mArm = 1; mIntCnt = 0;
    end
    if (chg) begin mCmpCnt = 0; mIntCnt = 0; end
    if (highWrEn) mHigh = sx(highWrData);
    if (lowWrEn)  mLow  = sx(lowWrData);
    if (cfgWrEn) begin mFault = cfgFaultSel; mInt = cfgIntMode; mPol = cfgPolarity; end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    int lvl;
    lvl = mInt ? mIntAlert : mCmp;
    check({curReq, " model pin"}, alertPin, !(lvl ^ mPol));
    check({curReq, " model status"}, statusBit, !(mCmp ^ mPol));
  endtask

  // One clock: inputs already driven (at negedge); compare after the edge
  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareModel();
    sampleValid = 0; highWrEn = 0; lowWrEn = 0; cfgWrEn = 0;
    regReadClr = 0; alertAckClr = 0; shutdownClr = 0; genReset = 0;
  endtask

  task automatic samp(int t);
    sampleValid = 1; sampleTemp = 12'(t);
    cyc();
  endtask

  task automatic setCfg(int fault, int intm, int pol);
    cfgWrEn = 1; cfgFaultSel = 2'(fault); cfgIntMode = intm[0]; cfgPolarity = pol[0];
    cyc();
  endtask

  initial begin
    modelReset();
    repeat (3) cyc();
    @(negedge clk);
    rst_n = 1;
    cyc();
    curReq = "R1";
    check("R1 pin after reset", alertPin, 1);
    check("R1 status after reset", statusBit, 1);
    samp(1279); check("R1 below default high", alertPin, 1);
    curReq = "R3";
    samp(1280); check("R3 at default high", alertPin, 0);
    check("R3 status", statusBit, 0);
    curReq = "R4";
    samp(1200); check("R4 equal to low holds", alertPin, 0);
    samp(1199); check("R4 below low releases", alertPin, 1);

    curReq = "R2";
    for (int code = 0; code < 4; code++) begin
      setCfg(code, 0, 0);
      for (int k = 0; k < needOf(code) - 1; k++) samp(1300);
      check("R2 one short of run", alertPin, 1);
      samp(1300);
      check("R2 run complete", alertPin, 0);
      for (int k = 0; k < needOf(code); k++) samp(1000);
      check("R2 release run", alertPin, 1);
    end

    curReq = "R5";
    setCfg(2, 0, 0);
    repeat (3) samp(1300);
    samp(1279);
    repeat (3) samp(1300);
    check("R5 broken run restarts", alertPin, 1);
    cyc(); cyc();
    samp(1300);
    check("R5 idle cycles keep run", alertPin, 0);
    repeat (4) samp(1000);

    curReq = "R11";
    setCfg(0, 0, 0);
    highWrEn = 1; highWrData = 12'hF00; lowWrEn = 1; lowWrData = 12'hE00; cyc();
    samp(12'hEFF); check("R11 negative below high", alertPin, 1);
    samp(12'hF00); check("R11 negative at high", alertPin, 0);
    samp(12'hE00); check("R11 negative equal low", alertPin, 0);
    samp(12'hDFF); check("R11 negative below low", alertPin, 1);
    highWrEn = 1; highWrData = 12'h501; lowWrEn = 1; lowWrData = 12'h4B0; cyc();
    samp(12'h500); check("R11 low bit of limit", alertPin, 1);
    samp(12'h501); check("R11 at odd limit", alertPin, 0);
    samp(12'h4AF); check("R11 release", alertPin, 1);
    highWrEn = 1; highWrData = 12'h500; cyc();

    curReq = "R9";
    setCfg(0, 0, 1);
    check("R9 inverted idle pin", alertPin, 0);
    check("R9 inverted idle status", statusBit, 0);
    samp(1300);
    check("R9 inverted active pin", alertPin, 1);
    check("R9 inverted active status", statusBit, 1);
    samp(1000);
    check("R9 inverted release", alertPin, 0);
    setCfg(0, 0, 0);

    curReq = "R12";
    sampleValid = 1; sampleTemp = 12'd1300;
    setCfg(1, 1, 0);
    samp(1300);
    check("R12 sample on mode change dropped", alertPin, 1);
    curReq = "R6";
    samp(1300);
    check("R6 interrupt fires", alertPin, 0);
    check("R10 status in interrupt mode", statusBit, 0);
    repeat (3) samp(1000);
    check("R6 latched despite low temps", alertPin, 0);
    check("R10 status released", statusBit, 1);
    curReq = "R7";
    regReadClr = 1; cyc();
    check("R7 read clears", alertPin, 1);
    curReq = "R8";
    repeat (3) samp(1300);
    check("R8 high ignored after clear", alertPin, 1);
    samp(1000); samp(1000);
    check("R8 low run fires", alertPin, 0);
    alertAckClr = 1; cyc();
    check("R7 ack clears", alertPin, 1);
    repeat (2) samp(1000);
    check("R8 low ignored when high armed", alertPin, 1);
    repeat (2) samp(1300);
    check("R8 high armed again", alertPin, 0);
    shutdownClr = 1; cyc();
    check("R7 shutdown clears", alertPin, 1);

    curReq = "R14";
    samp(1000);
    regReadClr = 1; samp(1000);
    check("R14 fire beats clear", alertPin, 0);

    curReq = "R13";
    genReset = 1; samp(1300);
    check("R13 pin after general reset", alertPin, 1);
    check("R13 status after general reset", statusBit, 1);
    samp(1279); check("R13 default high restored", alertPin, 1);
    samp(1280); check("R13 comparator fault 1", alertPin, 0);
    samp(1199);

    curReq = "R3 R4 R7 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      sampleValid = ($urandom_range(0, 3) != 0);
      sampleTemp  = 12'(1180 + $urandom_range(0, 120));
      if (r < 3) begin
        cfgWrEn = 1; cfgFaultSel = 2'($urandom_range(0, 3));
        cfgIntMode = 1'($urandom_range(0, 1)); cfgPolarity = 1'($urandom_range(0, 1));
      end
      if (r == 5) begin highWrEn = 1; highWrData = 12'(1240 + $urandom_range(0, 60)); end
      if (r == 6) begin lowWrEn = 1;  lowWrData  = 12'(1190 + $urandom_range(0, 50)); end
      regReadClr  = ($urandom_range(0, 19) == 0);
      alertAckClr = ($urandom_range(0, 39) == 0);
      shutdownClr = ($urandom_range(0, 59) == 0);
      genReset    = ($urandom_range(0, 499) == 0);
      cyc();
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule